// File: doc/BRIEF.md
# Multi-source interrupt request aggregator

This block gathers seven event sources into one active-low interrupt request line and keeps a sticky pending flag per source. A host that sees the request line low issues a status read; the block then presents a snapshot of every pending flag and clears exactly the flags it captured, so the host learns which events fired without losing any that arrive during the read.

The sources are: transmit register ready, FIFO fill threshold reached, power-on reset, FIFO overflow or transmit underrun (one shared flag), wake-up timer timeout, an external active-low interrupt pin, and low supply voltage. Most sources arrive as single-cycle strobes. The FIFO-related and transmit-related strobes only count while their path is enabled. The external pin is asynchronous: it is synchronized and only a low level that persists for a programmable number of clocks raises its flag, once per low period.

Top module: `irq_gather`

## Requirements
- R1: `irq_n` is low exactly while at least one pending flag is set; a strobe sampled at a clock edge makes its flag, and the low request, visible right after that edge.
- R2: After reset only the power-on flag (bit 0) is pending, so `irq_n` is low, and `stat_snap` is all zero.
- R3: The FIFO threshold flag (bit 2) is set by `ev_fifo_level` only while `fifo_path_en` is 1.
- R4: The transmit-ready flag (bit 1) is set by `ev_tx_ready` only while `tx_path_en` is 1.
- R5: The shared flag (bit 3) is set by `ev_fifo_overflow` while `fifo_path_en` is 1 and by `ev_tx_underrun` while `tx_path_en` is 1; a strobe whose path is disabled is ignored.
- R6: The wake-up flag (bit 4) and the low-supply flag (bit 6) are set by their strobes regardless of the path enables.
- R7: The external flag (bit 5) is set once `ext_int_n` has been low at LOW_MIN consecutive clock samples (after a SYNC_STAGES-flop synchronizer); a shorter low pulse sets nothing.
- R8: A single low period of `ext_int_n` sets the external flag at most once; a new flag needs the pin to return high first.
- R9: A `stat_rd` strobe sampled at an edge loads `stat_snap` with all pending flags from before that edge and clears them.
- R10: A strobe sampled at the same edge as `stat_rd` is not in that snapshot and stays pending afterwards.
- R11: A pending flag stays set, with no further events, until a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (acts as power-on reset) |
| fifo_path_en | input | 1 | Receive FIFO path enabled |
| tx_path_en | input | 1 | Transmit register path enabled |
| ev_tx_ready | input | 1 | Strobe: transmit register can take the next byte |
| ev_fifo_level | input | 1 | Strobe: FIFO reached its programmed fill level |
| ev_fifo_overflow | input | 1 | Strobe: FIFO overflow |
| ev_tx_underrun | input | 1 | Strobe: transmit register underrun |
| ev_wake_timer | input | 1 | Strobe: wake-up timer expired |
| ev_supply_low | input | 1 | Strobe: supply below threshold |
| ext_int_n | input | 1 | Asynchronous external interrupt pin, active low |
| stat_rd | input | 1 | Strobe: status read, snapshot and clear |
| irq_n | output | 1 | Active-low interrupt request |
| stat_snap | output | 7 | Flags captured by the last status read |

## Verification
The status read and a new event can land on the same clock edge, and the design must both report the old flags and keep the new one. The bench provokes this with random strobes that often coincide with random read strobes, plus a directed case where a read and a low-supply strobe share an edge. Each snapshot and each later request level is judged against a bench model that builds the gated event vector from the requirements and applies read-then-set ordering.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC    = 7;
    localparam int B_POR   = 0;
    localparam int B_TXRDY = 1;
    localparam int B_FLVL  = 2;
    localparam int B_OVUR  = 3;
    localparam int B_WAKE  = 4;
    localparam int B_EXT   = 5;
    localparam int B_LOWV  = 6;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t pend;
        src_vec_t snap;
    } bank_st_t;
endpackage

// File: rtl/irq_ext_filter.sv
module irq_ext_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fire
);
    localparam int CW = (LOW_MIN < 2) ? 1 : $clog2(LOW_MIN);
    localparam logic [CW-1:0] CNT_LAST = CW'(LOW_MIN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   armed;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    low_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        low_seen  = ~st_q.sync[SYNC_STAGES-1];
        fire      = low_seen & st_q.armed & (st_q.cnt == CNT_LAST);
        if (!low_seen) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else begin
            if (st_q.cnt != CNT_LAST) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (fire) begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // one pulse per low period
    p_ext_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // a pulse needs the synchronized pin low in the previous cycle as well
    p_ext_low_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && LOW_MIN > 1) |-> $past(low_seen));
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import irq_pkg::*;
(
    input  logic     fifo_path_en,
    input  logic     tx_path_en,
    input  logic     ev_tx_ready,
    input  logic     ev_fifo_level,
    input  logic     ev_fifo_overflow,
    input  logic     ev_tx_underrun,
    input  logic     ev_wake_timer,
    input  logic     ev_supply_low,
    input  logic     ext_fire,
    output src_vec_t ev_vec
);
    always_comb begin
        ev_vec          = '0;
        ev_vec[B_TXRDY] = ev_tx_ready & tx_path_en;
        ev_vec[B_FLVL]  = ev_fifo_level & fifo_path_en;
        ev_vec[B_OVUR]  = (ev_fifo_overflow & fifo_path_en)
                        | (ev_tx_underrun & tx_path_en);
        ev_vec[B_WAKE]  = ev_wake_timer;
        ev_vec[B_EXT]   = ext_fire;
        ev_vec[B_LOWV]  = ev_supply_low;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t ev_vec,
    input  logic     rd,
    output src_vec_t pend,
    output src_vec_t snap
);
    localparam src_vec_t POR_ONLY = src_vec_t'(1) << B_POR;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.snap = st_q.pend;
            st_d.pend = ev_vec;
        end else begin
            st_d.pend = st_q.pend | ev_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= POR_ONLY;
            st_q.snap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign snap = st_q.snap;

    p_por_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pend[B_POR]);
    p_snap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> snap == $past(pend));
    p_keep_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> pend == $past(ev_vec));
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (pend & $past(pend)) == $past(pend));
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_MIN     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_path_en,
    input  logic       tx_path_en,
    input  logic       ev_tx_ready,
    input  logic       ev_fifo_level,
    input  logic       ev_fifo_overflow,
    input  logic       ev_tx_underrun,
    input  logic       ev_wake_timer,
    input  logic       ev_supply_low,
    input  logic       ext_int_n,
    input  logic       stat_rd,
    output logic       irq_n,
    output logic [6:0] stat_snap
);
    logic     ext_fire;
    src_vec_t ev_vec;
    src_vec_t pend;
    src_vec_t snap;

    irq_ext_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_int_n),
        .fire  (ext_fire)
    );

    irq_src_gate u_gate (
        .fifo_path_en     (fifo_path_en),
        .tx_path_en       (tx_path_en),
        .ev_tx_ready      (ev_tx_ready),
        .ev_fifo_level    (ev_fifo_level),
        .ev_fifo_overflow (ev_fifo_overflow),
        .ev_tx_underrun   (ev_tx_underrun),
        .ev_wake_timer    (ev_wake_timer),
        .ev_supply_low    (ev_supply_low),
        .ext_fire         (ext_fire),
        .ev_vec           (ev_vec)
    );

    irq_flag_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vec (ev_vec),
        .rd     (stat_rd),
        .pend   (pend),
        .snap   (snap)
    );

    always_comb begin
        irq_n     = ~|pend;
        stat_snap = snap;
    end

    // gated sources stay clear while their path is off
    p_flvl_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_path_en && !pend[B_FLVL]) |=> !pend[B_FLVL]);
    p_txrdy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_path_en && !pend[B_TXRDY]) |=> !pend[B_TXRDY]);
    p_ovur_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_path_en && !tx_path_en && !pend[B_OVUR]) |=> !pend[B_OVUR]);
    p_wake_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wake_timer |=> pend[B_WAKE]);
    p_irq_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_supply_low |=> !irq_n);
endmodule

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
    localparam int LOW_MIN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_path_en = 1'b0, tx_path_en = 1'b0;
    logic ev_tx_ready = 1'b0, ev_fifo_level = 1'b0, ev_fifo_overflow = 1'b0;
    logic ev_tx_underrun = 1'b0, ev_wake_timer = 1'b0, ev_supply_low = 1'b0;
    logic ext_int_n = 1'b1, stat_rd = 1'b0;
    logic irq_n;
    logic [6:0] stat_snap;

    // values applied at the next step
    logic d_fen, d_ten, d_txr, d_flv, d_ov, d_ur, d_wk, d_lv, d_ext, d_rd;
    logic [6:0] exp_flags, exp_snap;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    irq_gather #(.SYNC_STAGES(2), .LOW_MIN(LOW_MIN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fifo_path_en(fifo_path_en), .tx_path_en(tx_path_en),
        .ev_tx_ready(ev_tx_ready), .ev_fifo_level(ev_fifo_level),
        .ev_fifo_overflow(ev_fifo_overflow), .ev_tx_underrun(ev_tx_underrun),
        .ev_wake_timer(ev_wake_timer), .ev_supply_low(ev_supply_low),
        .ext_int_n(ext_int_n), .stat_rd(stat_rd),
        .irq_n(irq_n), .stat_snap(stat_snap)
    );

    function automatic logic [6:0] gated(input logic fen, ten, txr, flv, ov, ur, wk, lv);
        logic [6:0] v;
        v    = '0;
        v[1] = txr & ten;
        v[2] = flv & fen;
        v[3] = (ov & fen) | (ur & ten);
        v[4] = wk;
        v[6] = lv;
        return v;
    endfunction

    task automatic check7(input logic [6:0] act, input logic [6:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        d_txr = 0; d_flv = 0; d_ov = 0; d_ur = 0; d_wk = 0; d_lv = 0; d_rd = 0;
    endtask

    task automatic step(input string tag);
        logic [6:0] nv;
        @(negedge clk);
        fifo_path_en = d_fen; tx_path_en = d_ten;
        ev_tx_ready = d_txr; ev_fifo_level = d_flv; ev_fifo_overflow = d_ov;
        ev_tx_underrun = d_ur; ev_wake_timer = d_wk; ev_supply_low = d_lv;
        ext_int_n = d_ext; stat_rd = d_rd;
        @(posedge clk);
        #1;
        nv = gated(d_fen, d_ten, d_txr, d_flv, d_ov, d_ur, d_wk, d_lv);
        if (d_rd) begin
            exp_snap  = exp_flags;
            exp_flags = nv;
        end else begin
            exp_flags = exp_flags | nv;
        end
        check7({6'd0, irq_n}, {6'd0, (exp_flags == 7'd0)}, {"R1 ", tag});
        check7(stat_snap, exp_snap, {"snapshot ", tag});
        clear_strobes();
    endtask

    task automatic ext_pulse(input int k, input logic expect_ext, input string tag);
        d_lv = 1; step(tag);
        d_ext = 0;
        for (int i = 0; i < k; i++) step(tag);
        d_ext = 1;
        for (int i = 0; i < 6; i++) step(tag);
        exp_flags[5] = expect_ext;
        d_rd = 1; step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        d_fen = 0; d_ten = 0; d_ext = 1; clear_strobes();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R2: reset state
        check7({6'd0, irq_n}, 7'd0, "R2 irq after reset");
        check7(stat_snap, 7'd0, "R2 snapshot after reset");
        exp_flags = 7'b0000001; exp_snap = 7'd0;
        d_rd = 1; step("R2 por flag");

        // R3: threshold ignored while FIFO path off, taken while on
        d_fen = 0; d_ten = 1; d_flv = 1; step("R3");
        d_rd = 1; step("R3 off");
        d_fen = 1; d_flv = 1; step("R3");
        d_rd = 1; step("R3 on");
        // R4: transmit ready gated by transmit path
        d_ten = 0; d_txr = 1; step("R4");
        d_rd = 1; step("R4 off");
        d_ten = 1; d_txr = 1; step("R4");
        d_rd = 1; step("R4 on");
        // R5: shared overflow/underrun flag
        d_fen = 1; d_ten = 0; d_ur = 1; step("R5");
        d_rd = 1; step("R5 underrun ignored");
        d_ov = 1; step("R5");
        d_rd = 1; step("R5 overflow");
        d_fen = 0; d_ten = 1; d_ov = 1; step("R5");
        d_rd = 1; step("R5 overflow ignored");
        d_ur = 1; step("R5");
        d_rd = 1; step("R5 underrun");
        // R6: ungated sources
        d_fen = 0; d_ten = 0; d_wk = 1; d_lv = 1; step("R6");
        d_rd = 1; step("R6 wake and supply");
        // R11: sticky
        d_wk = 1; step("R11");
        for (int i = 0; i < 5; i++) step("R11 hold");
        d_rd = 1; step("R11 read");
        // R10: event on the read edge
        d_lv = 1; step("R10");
        d_rd = 1; d_wk = 1; step("R10 read with event");
        d_rd = 1; step("R10 event kept");

        // R7: glitch filter
        ext_pulse(1, 1'b0, "R7 len1");
        ext_pulse(LOW_MIN - 1, 1'b0, "R7 short");
        ext_pulse(LOW_MIN, 1'b1, "R7 min");
        ext_pulse(LOW_MIN + 2, 1'b1, "R7 long");
        // R8: one flag per low period, rearm after high
        d_lv = 1; step("R8");
        d_ext = 0;
        for (int i = 0; i < 8; i++) step("R8");
        exp_flags[5] = 1'b1;
        d_rd = 1; d_lv = 1; step("R8 first");
        for (int i = 0; i < 8; i++) step("R8 held low");
        d_rd = 1; step("R8 no second flag");
        d_ext = 1;
        for (int i = 0; i < 4; i++) step("R8");
        d_lv = 1; d_ext = 0;
        for (int i = 0; i < LOW_MIN + 2; i++) step("R8");
        d_ext = 1;
        for (int i = 0; i < 6; i++) step("R8");
        exp_flags[5] = 1'b1;
        d_rd = 1; step("R8 rearmed");

        // random mix: R9, R10, R3..R6
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 16) == 0) d_fen = $urandom % 2;
            if (($urandom % 16) == 0) d_ten = $urandom % 2;
            d_txr = ($urandom % 4) == 0;
            d_flv = ($urandom % 4) == 0;
            d_ov  = ($urandom % 6) == 0;
            d_ur  = ($urandom % 6) == 0;
            d_wk  = ($urandom % 8) == 0;
            d_lv  = ($urandom % 8) == 0;
            d_rd  = ($urandom % 5) == 0;
            step("R9 R10 random");
        end
        d_rd = 1; step("R9 final");
        d_rd = 1; step("R9 empty");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule